// File: doc/BRIEF.md
# IR Pulse-Space Duration Sampler

This block measures a demodulated infrared input. The input passes through a two-flop synchronizer. The block then times each run of constant level (a mark or a space) in units of a programmable sample period. Each finished run becomes one byte: bit 7 is the level flag and bits 6:0 hold the tick count. The byte goes into an eight-entry buffer made of two four-byte halves. When a half has been filled, the block sets its interrupt and reports which half is ready. A small synchronous register port lets the host configure the block, read bytes and acknowledge interrupts.

The run tracker is a state machine with three states. RS_OFF is the receiver-disabled state. RS_MARK times a pulse (input high). RS_SPACE times a space (input low). The transitions are as follows:

- RS_OFF goes to RS_MARK or RS_SPACE on enable, according to the synchronized level.
- RS_MARK and RS_SPACE swap at a tick where the level differs. This emits the finished run.
- RS_MARK and RS_SPACE stay in place at a tick where the count reaches 127. This emits the overflow code 0x7F and restarts the count.
- Any state goes to RS_OFF when the receiver is disabled.

Register map:

| Address | Contents |
|---|---|
| 0 to 7 | Sample bytes, read only. Bytes 0 to 3 are half 0 and bytes 4 to 7 are half 1. |
| 8 | Control. Bit 0 is the receiver enable. |
| 9 | Period. Bits 6:0 give the period in microseconds. Bit 7 enables the overflow interrupt. |
| 10 | Status. Bit 0 is the ready half. Bit 1 is the interrupt pending flag, write 1 to clear. Bit 2 is the lost flag, write 1 to clear. |

Top module: `ir_run_sampler`

## Requirements
- R1: After reset, every register reads zero (control, period, status, and all buffer bytes), and irq_out is low.
- R2: Each sample byte has bit 7 set for a space (input low) and clear for a pulse (input high). Bits 6:0 hold the number of ticks the run lasted, where a tick that first sees the new level counts toward the new run.
- R3: When a run reaches 127 ticks, the block writes 0x7F with the run's level flag and restarts the count at zero, keeping the same level. A level change seen while the count is zero writes no byte.
- R4: A tick occurs every max(period,1) × TICKS_PER_US clocks. The level is examined only at ticks, so an input excursion that ends before the next tick (allowing for the two-flop synchronizer) is not recorded.
- R5: Bytes are stored at addresses 0 to 7 in arrival order, wrapping from 7 back to 0.
- R6: Storing the fourth byte of a half sets status bit 1 and irq_out. It also sets status bit 0 to that half: 0 for bytes 0 to 3, 1 for bytes 4 to 7.
- R7: Writing status with bit 1 set clears the interrupt and irq_out, and acknowledges both halves.
- R8: Filling a half while the other half is filled and unacknowledged sets status bit 2. This flag is sticky until status is written with bit 2 set.
- R9: When period bit 7 is set, storing an overflow byte also sets the interrupt. When period bit 7 is clear, an overflow byte alone leaves it low.
- R10: While control bit 0 is clear, no bytes are written and the write position returns to byte 0, so the first byte after re-enabling lands at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated IR level, high means pulse |
| host_addr | input | 4 | Register address |
| host_wr | input | 1 | Write strobe, sampled at the clock edge |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr, combinational |
| irq_out | output | 1 | Interrupt request |

## Verification
The bench aims at the following corner cases:

- **One-tick runs.** A design that restarted the count at zero on a change would report one tick short.
- **A one-cycle glitch between ticks.** A design that reacted to level changes between ticks would split a run into extra bytes.
- **A run of exactly 127 ticks followed by a change.** A wrong design would emit a zero-length byte after 0x7F.
- **A run of 130 ticks.** A wrong design might fail to keep the level flag after the overflow.
- **Re-enabling the receiver when the write position is mid-half.** A design that did not clear the position would mix stale and fresh bytes in one half.
- **Filling both halves without any acknowledge.** This must set the lost flag.
- **The overflow interrupt with its enable set and clear.** A design that ignored the enable bit would get this wrong.

// File: rtl/ir_smp_pkg.sv
package ir_smp_pkg;

    localparam int SMP_CNT_W = 7;
    localparam logic [SMP_CNT_W-1:0] RUN_SAT = '1;

    localparam logic [3:0] REG_CTRL   = 4'd8;
    localparam logic [3:0] REG_PERIOD = 4'd9;
    localparam logic [3:0] REG_STATUS = 4'd10;

    localparam int ST_READY_BIT = 0;
    localparam int ST_IRQ_BIT   = 1;
    localparam int ST_LOST_BIT  = 2;
    localparam int CTRL_EN_BIT  = 0;
    localparam int PER_OVF_BIT  = 7;

    typedef enum logic [1:0] {
        RS_OFF   = 2'd0,
        RS_MARK  = 2'd1,
        RS_SPACE = 2'd2
    } run_state_t;

    typedef struct packed {
        logic                 is_space;
        logic [SMP_CNT_W-1:0] ticks;
    } smp_t;

endpackage

// File: rtl/ir_smp_sync.sv
module ir_smp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] shreg;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shreg <= '0;
                else        shreg <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shreg <= '0;
                else        shreg <= {shreg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = shreg[STAGES-1];
endmodule

// File: rtl/ir_smp_tick.sv
module ir_smp_tick #(
    parameter int TICKS_PER_US = 4,
    parameter int PER_W        = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [PER_W-1:0] period_us,
    output logic             tick
);
    localparam int MUL_W = $clog2(TICKS_PER_US + 1);
    localparam int CNT_W = PER_W + MUL_W;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic [PER_W-1:0] per_eff;

    // A zero period behaves as one microsecond.
    assign per_eff = (period_us == '0) ? PER_W'(1) : period_us;
    assign limit   = CNT_W'(per_eff) * CNT_W'(TICKS_PER_US);
    assign tick    = run_en && (cnt >= limit - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (!run_en || tick) cnt <= '0;
        else                      cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/ir_smp_runfsm.sv
module ir_smp_runfsm
    import ir_smp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic tick,
    input  logic level,
    output logic emit,
    output smp_t emit_smp,
    output logic emit_ovf
);
    run_state_t           state, state_n;
    logic [SMP_CNT_W-1:0] cnt, cnt_n;
    logic                 cur_space;
    logic                 lvl_space;

    assign cur_space = (state == RS_SPACE);
    assign lvl_space = !level;

    // State register and run counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RS_OFF;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // Next state and outputs.
    always_comb begin
        state_n  = state;
        cnt_n    = cnt;
        emit     = 1'b0;
        emit_ovf = 1'b0;
        emit_smp = '0;
        unique case (state)
            RS_OFF: begin
                cnt_n = '0;
                if (run_en) state_n = level ? RS_MARK : RS_SPACE;
            end
            RS_MARK, RS_SPACE: begin
                if (!run_en) begin
                    state_n = RS_OFF;
                    cnt_n   = '0;
                end else if (tick) begin
                    if (lvl_space != cur_space) begin
                        // Run finished; the current tick starts the new run.
                        emit     = (cnt != '0);
                        emit_smp = '{is_space: cur_space, ticks: cnt};
                        cnt_n    = SMP_CNT_W'(1);
                        state_n  = lvl_space ? RS_SPACE : RS_MARK;
                    end else if (cnt == RUN_SAT - SMP_CNT_W'(1)) begin
                        emit     = 1'b1;
                        emit_ovf = 1'b1;
                        emit_smp = '{is_space: cur_space, ticks: RUN_SAT};
                        cnt_n    = '0;
                    end else begin
                        cnt_n = cnt + SMP_CNT_W'(1);
                    end
                end
            end
            default: begin
                state_n = RS_OFF;
                cnt_n   = '0;
            end
        endcase
    end
endmodule

// File: rtl/ir_smp_buf.sv
module ir_smp_buf
    import ir_smp_pkg::*;
#(
    parameter int HALF_DEPTH = 4,
    localparam int BUF_DEPTH = 2 * HALF_DEPTH,
    localparam int PTR_W     = $clog2(BUF_DEPTH),
    localparam int LOW_W     = $clog2(HALF_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             emit,
    input  smp_t             emit_smp,
    input  logic             emit_ovf,
    input  logic             ovf_irq_en,
    input  logic             ack_irq,
    input  logic             clr_lost,
    input  logic [PTR_W-1:0] rd_idx,
    output logic [7:0]       rd_byte,
    output logic             ready_half,
    output logic             irq_pend,
    output logic             lost_flag
);
    logic [PTR_W-1:0] wr_ptr;
    logic             cur_half;
    logic             half_done;
    logic [1:0]       half_full;
    logic [7:0]       mem [BUF_DEPTH];

    assign cur_half  = wr_ptr[PTR_W-1];
    assign half_done = emit && (wr_ptr[LOW_W-1:0] == LOW_W'(HALF_DEPTH - 1));

    generate
        for (genvar i = 0; i < BUF_DEPTH; i++) begin : g_slot
            logic [7:0] slot_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                               slot_q <= '0;
                else if (emit && wr_ptr == PTR_W'(i))     slot_q <= emit_smp;
            end
            assign mem[i] = slot_q;
        end
    endgenerate

    assign rd_byte = mem[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        wr_ptr <= '0;
        else if (!run_en)  wr_ptr <= '0;
        else if (emit)     wr_ptr <= wr_ptr + PTR_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_half <= 1'b0;
            irq_pend   <= 1'b0;
            lost_flag  <= 1'b0;
            half_full  <= '0;
        end else begin
            if (ack_irq) begin
                irq_pend  <= 1'b0;
                half_full <= '0;
            end
            if (clr_lost) lost_flag <= 1'b0;
            if (half_done) begin
                half_full[cur_half] <= 1'b1;
                ready_half          <= cur_half;
                irq_pend            <= 1'b1;
                if (half_full[!cur_half] && !ack_irq) lost_flag <= 1'b1;
            end
            if (emit && emit_ovf && ovf_irq_en) irq_pend <= 1'b1;
        end
    end
endmodule

// File: rtl/ir_run_sampler.sv
module ir_run_sampler
    import ir_smp_pkg::*;
#(
    parameter int TICKS_PER_US = 4,
    parameter int HALF_DEPTH   = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ir_in,
    input  logic [3:0] host_addr,
    input  logic       host_wr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       irq_out
);
    localparam int BUF_DEPTH = 2 * HALF_DEPTH;
    localparam int PTR_W     = $clog2(BUF_DEPTH);
    localparam int PER_W     = 7;

    logic       rx_en;
    logic [7:0] period_reg;
    logic       level_s;
    logic       tick;
    logic       emit;
    smp_t       emit_smp;
    logic       emit_ovf;
    logic       ack_irq;
    logic       clr_lost;
    logic [7:0] buf_byte;
    logic       ready_half;
    logic       irq_pend;
    logic       lost_flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_en      <= 1'b0;
            period_reg <= '0;
        end else if (host_wr) begin
            if (host_addr == REG_CTRL)   rx_en      <= host_wdata[CTRL_EN_BIT];
            if (host_addr == REG_PERIOD) period_reg <= host_wdata;
        end
    end

    assign ack_irq  = host_wr && (host_addr == REG_STATUS) && host_wdata[ST_IRQ_BIT];
    assign clr_lost = host_wr && (host_addr == REG_STATUS) && host_wdata[ST_LOST_BIT];

    ir_smp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ir_in),
        .q     (level_s)
    );

    ir_smp_tick #(.TICKS_PER_US(TICKS_PER_US), .PER_W(PER_W)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (rx_en),
        .period_us (period_reg[PER_W-1:0]),
        .tick      (tick)
    );

    ir_smp_runfsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (rx_en),
        .tick     (tick),
        .level    (level_s),
        .emit     (emit),
        .emit_smp (emit_smp),
        .emit_ovf (emit_ovf)
    );

    ir_smp_buf #(.HALF_DEPTH(HALF_DEPTH)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (rx_en),
        .emit       (emit),
        .emit_smp   (emit_smp),
        .emit_ovf   (emit_ovf),
        .ovf_irq_en (period_reg[PER_OVF_BIT]),
        .ack_irq    (ack_irq),
        .clr_lost   (clr_lost),
        .rd_idx     (host_addr[PTR_W-1:0]),
        .rd_byte    (buf_byte),
        .ready_half (ready_half),
        .irq_pend   (irq_pend),
        .lost_flag  (lost_flag)
    );

    always_comb begin
        host_rdata = '0;
        if (host_addr < 4'(BUF_DEPTH)) begin
            host_rdata = buf_byte;
        end else begin
            case (host_addr)
                REG_CTRL:   host_rdata[CTRL_EN_BIT] = rx_en;
                REG_PERIOD: host_rdata = period_reg;
                REG_STATUS: begin
                    host_rdata[ST_READY_BIT] = ready_half;
                    host_rdata[ST_IRQ_BIT]   = irq_pend;
                    host_rdata[ST_LOST_BIT]  = lost_flag;
                end
                default: host_rdata = '0;
            endcase
        end
    end

    assign irq_out = irq_pend;
endmodule

// File: rtl/ir_run_sampler_chk.sv
module ir_run_sampler_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic       tick,
    input logic       emit,
    input logic [7:0] emit_smp,
    input logic       ack_irq,
    input logic       clr_lost,
    input logic       irq_out,
    input logic       ready_half,
    input logic       lost_flag
);
    p_off_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |-> !emit);

    p_emit_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        emit |-> tick);

    p_no_zero_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        emit |-> (emit_smp[6:0] != 7'd0));

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_irq && !emit) |=> !irq_out);

    p_lost_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_flag && !clr_lost) |=> lost_flag);

    p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(emit));

    p_half_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ready_half) |-> $past(emit));
endmodule

bind ir_run_sampler ir_run_sampler_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .tick       (tick),
    .emit       (emit),
    .emit_smp   (emit_smp),
    .ack_irq    (ack_irq),
    .clr_lost   (clr_lost),
    .irq_out    (irq_out),
    .ready_half (ready_half),
    .lost_flag  (lost_flag)
);

// File: tb/ir_run_sampler_test.sv
`timescale 1ns/1ps
module ir_run_sampler_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ir_in = 1'b0;
    logic [3:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       irq_out;

    int n_checks = 0;
    int n_errs = 0;
    int P = 8;
    bit mon_on = 1'b0;
    int mon_halves = 0;
    bit exp_half = 1'b0;
    logic [7:0] exp_q[$];
    bit done = 1'b0;

    localparam logic [3:0] A_CTRL = 4'd8, A_PER = 4'd9, A_STAT = 4'd10;

    always #2 clk = ~clk;

    ir_run_sampler uut (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .host_addr(host_addr),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq_out(irq_out)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [3:0] a, output logic [7:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic push_run(input bit lvl, input int ticks);
        int t = ticks;
        while (t >= 127) begin
            exp_q.push_back({~lvl, 7'h7F});
            t -= 127;
        end
        if (t > 0) exp_q.push_back({~lvl, 7'(t)});
    endtask

    // Driver: holds a level for a number of ticks, optionally pushing the expected byte.
    task automatic drive_run(input bit lvl, input int ticks, input bit push, input bit glitch);
        if (push) push_run(lvl, ticks);
        ir_in = lvl;
        if (glitch) begin
            repeat (P) @(posedge clk);
            #1 ir_in = ~lvl;
            @(posedge clk);
            #1 ir_in = lvl;
            repeat (ticks * P - P - 1) @(posedge clk);
        end else begin
            repeat (ticks * P) @(posedge clk);
        end
        #1;
    endtask

    task automatic start_stream();
        host_write(A_CTRL, 8'h01);
        @(posedge clk);
        #1;
    endtask

    task automatic wait_halves(input int n);
        while (mon_halves < n) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    endtask

    // Monitor: pops expected bytes as halves complete.
    initial begin
        logic [7:0] st, b;
        forever begin
            @(posedge irq_out);
            if (mon_on) begin
                @(negedge clk);
                host_read(A_STAT, st);
                check8("R6 irq pending bit", {7'd0, st[1]}, 8'h01);
                check8("R6 ready half", {7'd0, st[0]}, {7'd0, exp_half});
                for (int i = 0; i < 4; i++) begin
                    host_read(4'(st[0] * 4 + i), b);
                    if (exp_q.size() == 0) begin
                        check8("R5 unexpected sample", b, 8'hxx);
                    end else begin
                        check8("R2/R4/R5 sample byte", b, exp_q.pop_front());
                    end
                end
                exp_half = ~exp_half;
                host_write(A_STAT, 8'h02);
                mon_halves++;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        host_read(A_STAT, r); check8("R1 status", r, 8'h00);
        host_read(A_CTRL, r); check8("R1 control", r, 8'h00);
        host_read(A_PER, r);  check8("R1 period", r, 8'h00);
        host_read(4'd0, r);   check8("R1 byte0", r, 8'h00);
        host_read(4'd7, r);   check8("R1 byte7", r, 8'h00);
        check8("R1 irq_out", {7'd0, irq_out}, 8'h00);

        // Main stream, period 2 us -> 8 clocks per tick
        mon_on = 1'b1;
        P = 8;
        host_write(A_PER, 8'h02);
        start_stream();
        drive_run(1'b0, 3, 1, 0);
        drive_run(1'b1, 5, 1, 0);
        drive_run(1'b0, 2, 1, 1);   // R4: glitch between ticks is ignored
        drive_run(1'b1, 7, 1, 0);
        drive_run(1'b0, 4, 1, 0);
        drive_run(1'b1, 1, 1, 0);
        drive_run(1'b0, 10, 1, 0);
        drive_run(1'b1, 6, 1, 0);
        drive_run(1'b0, 2, 0, 0);   // emits 0x06; its own byte 0x82 goes to byte 0
        drive_run(1'b1, 3, 0, 0);   // emits 0x03 to byte 1
        drive_run(1'b0, 2, 0, 0);
        wait_halves(2);
        check8("R5 queue drained", 8'(exp_q.size()), 8'h00);
        host_read(A_STAT, r);
        check8("R8 no lost when acked", {7'd0, r[2]}, 8'h00);
        check8("R7 irq_out after ack", {7'd0, irq_out}, 8'h00);

        // R10: disabled receiver ignores input
        host_write(A_CTRL, 8'h00);
        for (int k = 0; k < 12; k++) begin
            ir_in = ~ir_in;
            repeat (9) @(posedge clk);
        end
        #1;
        host_read(4'd2, r); check8("R10 byte2 untouched", r, 8'h82);
        host_read(4'd0, r); check8("R10 byte0 untouched", r, 8'h82);
        check8("R10 irq_out stays low", {7'd0, irq_out}, 8'h00);

        // R10 + R4: restart at byte 0 with period 1 us -> 4 clocks per tick
        ir_in = 1'b0;
        P = 4;
        host_write(A_PER, 8'h01);
        exp_half = 1'b0;
        start_stream();
        drive_run(1'b0, 2, 1, 0);
        drive_run(1'b1, 3, 1, 0);
        drive_run(1'b0, 1, 1, 0);
        drive_run(1'b1, 4, 1, 0);
        drive_run(1'b0, 2, 0, 0);
        wait_halves(3);
        check8("R10 restart half consumed", 8'(exp_q.size()), 8'h00);

        // R3 / R9: overflow handling
        mon_on = 1'b0;
        host_write(A_CTRL, 8'h00);
        P = 8;
        host_write(A_PER, 8'h02);
        host_write(A_STAT, 8'h06);
        ir_in = 1'b0;
        start_stream();
        drive_run(1'b0, 127, 0, 0);
        check8("R9 no irq when ovf irq disabled", {7'd0, irq_out}, 8'h00);
        fork
            begin
                drive_run(1'b1, 2, 0, 0);
                drive_run(1'b0, 130, 0, 0);
                check8("R9 irq on overflow sample", {7'd0, irq_out}, 8'h01);
                drive_run(1'b1, 1, 0, 0);
                drive_run(1'b0, 2, 0, 0);
            end
            begin
                repeat (4) @(posedge clk);
                host_write(A_PER, 8'h82);
            end
        join
        host_read(4'd0, r); check8("R3 overflow space", r, 8'hFF);
        host_read(4'd1, r); check8("R3 no zero-length after exact 127", r, 8'h02);
        host_read(4'd2, r); check8("R3 second overflow", r, 8'hFF);
        host_read(4'd3, r); check8("R3 remainder keeps level", r, 8'h83);
        host_read(4'd4, r); check8("R5 next half byte", r, 8'h01);

        // R7 / R8: lost flag
        host_write(A_CTRL, 8'h00);
        host_write(A_PER, 8'h02);
        host_write(A_STAT, 8'h06);
        check8("R7 ack drops irq_out", {7'd0, irq_out}, 8'h00);
        ir_in = 1'b0;
        start_stream();
        for (int k = 0; k < 9; k++) drive_run(k[0], 2, 0, 0);
        host_read(A_STAT, r); check8("R8 lost set, half 1 ready", r, 8'h07);
        host_write(A_STAT, 8'h04);
        host_read(A_STAT, r); check8("R8 lost cleared only", r, 8'h03);
        host_write(A_STAT, 8'h02);
        host_read(A_STAT, r); check8("R7 irq cleared", r, 8'h01);
        check8("R7 irq_out low", {7'd0, irq_out}, 8'h00);

        done = 1'b1;
        finish_run();
    end
endmodule